// File: doc/BRIEF.md
# Page-Load Write Controller

This block sits between a host byte-write port and a non-volatile storage array that is programmed one page at a time. The host offers bytes one by one. The first accepted byte opens a load window and fixes the page for that window. Later bytes of the same page go into an on-block page buffer. They may arrive in any order and may hit the same offset more than once. The window stays open while bytes keep arriving. Once `LOAD_TIMEOUT` clock cycles pass without a byte being stored, the window closes and the block starts an internal write.

The internal write has two parts. First, the page buffer is streamed to the array in ascending offset order over a valid/ready interface. Any offset that was never loaded goes out as the erased value `FF`. Second, the block holds a programme interval of `PROG_CYCLES` cycles. The busy flag covers both parts, and the host port refuses new bytes until busy falls.

Two control pins lock boot regions, one at the bottom of the address space and one at the top. When a window closes on a locked page, the whole page is thrown away and no write cycle starts. A byte whose page differs from the latched page is dropped, and a sticky error flag is set.

Top module: `plw_page_writer`

## Requirements
- R1: The low `OFS_W` (8) address bits give the byte offset and the upper `ADDR_W-OFS_W` bits give the page. The page taken from the first byte of a window appears on `aw_page` and holds steady for the whole write cycle.
- R2: Bytes may be loaded in any order. When one offset is loaded more than once in a window, the array receives the last value loaded.
- R3: A window stays open while each stored byte is accepted within `LOAD_TIMEOUT` clock edges of the previous one. A byte accepted on exactly the `LOAD_TIMEOUT`-th edge still extends the window. If no byte is stored, `busy` reads 1 after the `LOAD_TIMEOUT`-th edge following the last stored byte, and 0 one edge before that.
- R4: Every offset not loaded during the window is written to the array as `8'hFF`.
- R5: A byte with a page different from the latched page is accepted at the port but dropped. It changes no array data and does not extend the window. It sets `page_err`, which stays 1 until reset.
- R6: `busy` covers the whole drain. It then stays 1 for exactly `PROG_CYCLES` edges after the edge that takes the last beat. `ld_ready` is 0 whenever `busy` is 1.
- R7: The drain stream sends offsets 0 to 255 in ascending order, one beat per `aw_valid && aw_ready` edge, with `aw_last` on offset 255. While `aw_ready` is low, `aw_valid`, `aw_offset` and `aw_data` hold steady.
- R8: `lock_low` protects pages below `BOOT_BYTES/256`, and `lock_high` protects the same number of pages at the top. A window that closes on a protected page raises neither `busy` nor `aw_valid`, and its bytes do not reach any later write.
- R9: After reset: `busy`=0, `aw_valid`=0, `ld_ready`=1, `page_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | Host byte offered |
| ld_ready | output | 1 | Block can take a byte (low while busy) |
| ld_addr | input | ADDR_W | Byte address: page in upper bits, offset in low 8 |
| ld_data | input | DATA_W | Byte value |
| lock_low | input | 1 | Protect the bottom boot region |
| lock_high | input | 1 | Protect the top boot region |
| busy | output | 1 | Internal write in progress |
| page_err | output | 1 | Sticky: a byte for another page was dropped |
| aw_valid | output | 1 | Array-write beat valid |
| aw_ready | input | 1 | Array accepts the beat |
| aw_page | output | ADDR_W-OFS_W | Page being written |
| aw_offset | output | OFS_W | Byte offset of the beat |
| aw_data | output | DATA_W | Byte value of the beat |
| aw_last | output | 1 | Final beat of the page |

## Verification
The bench offers a byte on exactly the last edge the window allows. A design with an off-by-one timer would close the window early and split the page into two writes. It sends a stray-page byte right after a valid one. A design that restarts the timer on a dropped byte would move the start of busy, and one that stores the byte would corrupt the drained data. It also reloads the same offset and leaves most offsets empty, which exposes a buffer that keeps the first value or emits stale bytes in place of `FF`. Finally, it starts a window on a locked page and then loads the same page unlocked. A design that does not clear the valid mask on suppression would leak the discarded byte into the next write.

// File: rtl/plw_pkg.sv
package plw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_PROG  = 2'd3
  } plw_state_e;
endpackage

// File: rtl/plw_interval.sv
// Cycle counter: done is high in the cycle where LIMIT-1 counts are complete.
module plw_interval #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;

  assign done = run && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clear)          cnt_q <= '0;
    else if (run && !done)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/plw_page_buf.sv
// Page storage with a per-offset loaded mask; unloaded offsets read as erased.
module plw_page_buf #(
  parameter int unsigned OFS_W  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  wr_ofs,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [OFS_W-1:0]  rd_ofs,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << OFS_W;
  localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  mask_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_ofs] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_q <= '0;
    else if (clr)    mask_q <= '0;
    else if (wr_en)  mask_q[wr_ofs] <= 1'b1;
  end

  assign rd_data = mask_q[rd_ofs] ? mem_q[rd_ofs] : ERASED;
endmodule

// File: rtl/plw_region_lock.sv
// Flags pages inside a protected boot region at either end of the space.
module plw_region_lock #(
  parameter int unsigned PAGE_W     = 11,
  parameter int unsigned BOOT_PAGES = 64
) (
  input  logic [PAGE_W-1:0] page,
  input  logic              lock_lo,
  input  logic              lock_hi,
  output logic              locked
);
  localparam int unsigned NUM_PAGES = 1 << PAGE_W;

  generate
    if (BOOT_PAGES == 0) begin : g_none
      assign locked = 1'b0;
    end else begin : g_regions
      localparam logic [PAGE_W-1:0] LO_END  = PAGE_W'(BOOT_PAGES);
      localparam logic [PAGE_W-1:0] HI_BASE = PAGE_W'(NUM_PAGES - BOOT_PAGES);
      logic lo_hit, hi_hit;
      assign lo_hit = lock_lo && (page < LO_END);
      assign hi_hit = lock_hi && (page >= HI_BASE);
      assign locked = lo_hit || hi_hit;
    end
  endgenerate
endmodule

// File: rtl/plw_page_writer.sv
module plw_page_writer
  import plw_pkg::*;
#(
  parameter int unsigned ADDR_W       = 19,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned OFS_W        = 8,
  parameter int unsigned LOAD_TIMEOUT = 32,
  parameter int unsigned PROG_CYCLES  = 64,
  parameter int unsigned BOOT_BYTES   = 16384
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_valid,
  output logic                     ld_ready,
  input  logic [ADDR_W-1:0]        ld_addr,
  input  logic [DATA_W-1:0]        ld_data,
  input  logic                     lock_low,
  input  logic                     lock_high,
  output logic                     busy,
  output logic                     page_err,
  output logic                     aw_valid,
  input  logic                     aw_ready,
  output logic [ADDR_W-OFS_W-1:0]  aw_page,
  output logic [OFS_W-1:0]         aw_offset,
  output logic [DATA_W-1:0]        aw_data,
  output logic                     aw_last
);
  localparam int unsigned PAGE_W     = ADDR_W - OFS_W;
  localparam int unsigned BOOT_PAGES = BOOT_BYTES >> OFS_W;

  plw_state_e          state_q;
  logic [PAGE_W-1:0]   page_q;
  logic [OFS_W-1:0]    idx_q;
  logic                err_q;

  logic [OFS_W-1:0]    in_ofs;
  logic [PAGE_W-1:0]   in_page;
  logic take, first_hit, same_hit, stray_hit, buf_wr;
  logic win_done, expire, locked, beat, idx_top, prog_done, buf_clr;
  logic [DATA_W-1:0]   rd_byte;

  assign in_ofs   = ld_addr[OFS_W-1:0];
  assign in_page  = ld_addr[ADDR_W-1:OFS_W];

  assign ld_ready  = (state_q == ST_IDLE) || (state_q == ST_LOAD);
  assign take      = ld_valid && ld_ready;
  assign first_hit = take && (state_q == ST_IDLE);
  assign same_hit  = take && (state_q == ST_LOAD) && (in_page == page_q);
  assign stray_hit = take && (state_q == ST_LOAD) && (in_page != page_q);
  assign buf_wr    = first_hit || same_hit;

  // Inactivity window: restarted by every stored byte, not by stray ones.
  plw_interval #(.LIMIT(LOAD_TIMEOUT)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (buf_wr || (state_q != ST_LOAD)),
    .run   (state_q == ST_LOAD),
    .done  (win_done)
  );
  assign expire = win_done && !same_hit;

  plw_region_lock #(.PAGE_W(PAGE_W), .BOOT_PAGES(BOOT_PAGES)) u_lock (
    .page    (page_q),
    .lock_lo (lock_low),
    .lock_hi (lock_high),
    .locked  (locked)
  );

  assign beat    = (state_q == ST_DRAIN) && aw_ready;
  assign idx_top = (idx_q == {OFS_W{1'b1}});

  plw_interval #(.LIMIT(PROG_CYCLES)) u_prog (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (state_q != ST_PROG),
    .run   (state_q == ST_PROG),
    .done  (prog_done)
  );

  assign buf_clr = (expire && locked) || prog_done;

  plw_page_buf #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (buf_wr),
    .wr_ofs  (in_ofs),
    .wr_data (ld_data),
    .clr     (buf_clr),
    .rd_ofs  (idx_q),
    .rd_data (rd_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (first_hit) begin
          state_q <= ST_LOAD;
          page_q  <= in_page;
        end
        ST_LOAD: if (expire) begin
          state_q <= locked ? ST_IDLE : ST_DRAIN;
          idx_q   <= '0;
        end
        ST_DRAIN: if (beat) begin
          idx_q <= idx_q + 1'b1;
          if (idx_top) state_q <= ST_PROG;
        end
        ST_PROG: if (prog_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         err_q <= 1'b0;
    else if (stray_hit) err_q <= 1'b1;
  end

  assign busy      = (state_q == ST_DRAIN) || (state_q == ST_PROG);
  assign page_err  = err_q;
  assign aw_valid  = (state_q == ST_DRAIN);
  assign aw_page   = page_q;
  assign aw_offset = idx_q;
  assign aw_data   = rd_byte;
  assign aw_last   = aw_valid && idx_top;
endmodule

// File: rtl/plw_page_writer_chk.sv
module plw_page_writer_chk #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OFS_W  = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ld_ready,
  input logic                    busy,
  input logic                    page_err,
  input logic                    aw_valid,
  input logic                    aw_ready,
  input logic [ADDR_W-OFS_W-1:0] aw_page,
  input logic [OFS_W-1:0]        aw_offset,
  input logic [DATA_W-1:0]       aw_data,
  input logic                    aw_last
);
  p_busy_blocks_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ld_ready);

  p_beat_only_when_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid |-> busy);

  p_beat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && !aw_ready) |=> (aw_valid && $stable(aw_offset) && $stable(aw_data)));

  p_offset_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && aw_ready && !aw_last) |=> (aw_valid && aw_offset == $past(aw_offset) + 1'b1));

  p_last_at_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && aw_last) |-> (aw_offset == {OFS_W{1'b1}}));

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |=> page_err);

  p_page_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(aw_page)));
endmodule

bind plw_page_writer plw_page_writer_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .OFS_W  (OFS_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_ready  (ld_ready),
  .busy      (busy),
  .page_err  (page_err),
  .aw_valid  (aw_valid),
  .aw_ready  (aw_ready),
  .aw_page   (aw_page),
  .aw_offset (aw_offset),
  .aw_data   (aw_data),
  .aw_last   (aw_last)
);

// File: tb/plw_page_writer_tb.sv
`timescale 1ns/1ps
module plw_page_writer_tb;
  localparam int ADDR_W = 19;
  localparam int DATA_W = 8;
  localparam int OFS_W  = 8;
  localparam int T      = 32;
  localparam int PC     = 64;
  localparam int PAGE_W = ADDR_W - OFS_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 1'b0;
  logic [ADDR_W-1:0] ld_addr = '0;
  logic [DATA_W-1:0] ld_data = '0;
  logic lock_low = 1'b0, lock_high = 1'b0;
  logic aw_ready = 1'b0;
  logic ld_ready, busy, page_err, aw_valid, aw_last;
  logic [PAGE_W-1:0] aw_page;
  logic [OFS_W-1:0]  aw_offset;
  logic [DATA_W-1:0] aw_data;

  int tests = 0;
  int fails = 0;
  logic [7:0] exp_mem [256];

  always #2 clk = ~clk;

  plw_page_writer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W),
    .LOAD_TIMEOUT(T), .PROG_CYCLES(PC), .BOOT_BYTES(16384)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data), .lock_low(lock_low), .lock_high(lock_high),
    .busy(busy), .page_err(page_err), .aw_valid(aw_valid), .aw_ready(aw_ready),
    .aw_page(aw_page), .aw_offset(aw_offset), .aw_data(aw_data), .aw_last(aw_last)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic clear_exp();
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'hFF;
  endtask

  // Called at a negedge; the byte is taken on the next posedge; returns at the following negedge.
  task automatic load_byte(input int page, input int ofs, input logic [7:0] d);
    ld_valid = 1'b1;
    ld_addr  = ADDR_W'((page << OFS_W) | ofs);
    ld_data  = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  // Called at the negedge after the last stored byte's edge.
  task automatic expect_close(input string tag);
    repeat (T - 1) @(negedge clk);
    chk(busy == 1'b0, {tag, " R3 busy low before timeout"}, busy, 0);
    @(negedge clk);
    chk(busy == 1'b1, {tag, " R3 busy high at timeout"}, busy, 1);
  endtask

  task automatic drain(input int page, input bit stall, input string tag);
    int nexp = 0, bad_data = 0, bad_ord = 0, bad_hold = 0, bad_page = 0, bad_rdy = 0;
    int cyc = 0, bad_ofs = -1;
    logic held = 1'b0;
    logic [7:0] h_ofs = '0, h_dat = '0;
    while (nexp < 256 && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      aw_ready = stall ? ((cyc % 3) != 0) : 1'b1;
      if (ld_ready) bad_rdy++;
      if (aw_valid) begin
        if (held && (aw_offset != h_ofs || aw_data != h_dat)) bad_hold++;
        if (aw_page != PAGE_W'(page)) bad_page++;
        if (aw_ready) begin
          if (aw_offset != OFS_W'(nexp) || aw_last != (nexp == 255)) bad_ord++;
          if (aw_data != exp_mem[aw_offset]) begin
            bad_data++;
            if (bad_ofs < 0) bad_ofs = aw_offset;
          end
          nexp++;
          held = 1'b0;
        end else begin
          held = 1'b1; h_ofs = aw_offset; h_dat = aw_data;
        end
      end else if (nexp > 0) bad_ord++;
    end
    chk(nexp == 256, {tag, " R7 beat count"}, nexp, 256);
    chk(bad_ord == 0, {tag, " R7 ascending offsets and last flag"}, bad_ord, 0);
    chk(bad_data == 0, {tag, " R2 R4 drained bytes"}, bad_ofs, -1);
    chk(bad_page == 0, {tag, " R1 page on stream"}, bad_page, 0);
    chk(bad_rdy == 0, {tag, " R6 ld_ready low during drain"}, bad_rdy, 0);
    if (stall) chk(bad_hold == 0, {tag, " R7 held under back-pressure"}, bad_hold, 0);
    // Last beat taken on the coming posedge P; busy must last PC edges after P.
    repeat (PC) @(negedge clk);
    aw_ready = 1'b0;
    chk(busy == 1'b1 && ld_ready == 1'b0, {tag, " R6 busy through programme"}, busy, 1);
    @(negedge clk);
    chk(busy == 1'b0 && ld_ready == 1'b1, {tag, " R6 busy ends after programme"}, busy, 0);
  endtask

  task automatic t_reset();
    chk(busy == 0, "R9 busy at reset", busy, 0);
    chk(aw_valid == 0, "R9 aw_valid at reset", aw_valid, 0);
    chk(ld_ready == 1, "R9 ld_ready at reset", ld_ready, 1);
    chk(page_err == 0, "R9 page_err at reset", page_err, 0);
  endtask

  task automatic t_basic();
    clear_exp();
    load_byte(5, 8'h10, 8'hA1);
    load_byte(5, 8'h03, 8'hB2);
    load_byte(5, 8'hFF, 8'hC3);
    load_byte(5, 8'h00, 8'h5A);
    load_byte(5, 8'h10, 8'hD4);
    exp_mem[8'h10] = 8'hD4; exp_mem[8'h03] = 8'hB2;
    exp_mem[8'hFF] = 8'hC3; exp_mem[8'h00] = 8'h5A;
    expect_close("basic");
    drain(5, 1'b0, "basic");
  endtask

  task automatic t_window_edge();
    clear_exp();
    load_byte(9, 8'h40, 8'h11);
    repeat (T - 1) @(negedge clk);
    chk(busy == 0, "R3 window still open at last edge", busy, 0);
    load_byte(9, 8'h41, 8'h22);
    exp_mem[8'h40] = 8'h11; exp_mem[8'h41] = 8'h22;
    expect_close("edge");
    drain(9, 1'b0, "edge");
  endtask

  task automatic t_backpressure();
    clear_exp();
    for (int i = 0; i < 8; i++) begin
      load_byte(100, 255 - 17 * i, 8'(i * 7 + 3));
      exp_mem[255 - 17 * i] = 8'(i * 7 + 3);
    end
    expect_close("stall");
    drain(100, 1'b1, "stall");
  endtask

  task automatic t_stray();
    clear_exp();
    load_byte(20, 8'h07, 8'h33);
    load_byte(21, 8'h08, 8'h44);
    exp_mem[8'h07] = 8'h33;
    chk(page_err == 1, "R5 page_err set by stray byte", page_err, 1);
    repeat (T - 2) @(negedge clk);
    chk(busy == 0, "R5 stray byte no effect before timeout", busy, 0);
    @(negedge clk);
    chk(busy == 1, "R5 stray byte does not extend window", busy, 1);
    drain(20, 1'b0, "stray");
    chk(page_err == 1, "R5 page_err sticky", page_err, 1);
  endtask

  task automatic t_lock();
    int seen = 0;
    lock_low = 1'b1;
    load_byte(3, 8'h07, 8'h55);
    repeat (T + 8) begin
      @(negedge clk);
      if (busy || aw_valid) seen++;
    end
    chk(seen == 0, "R8 low region suppressed", seen, 0);
    chk(ld_ready == 1, "R8 port free after suppression", ld_ready, 1);
    lock_low = 1'b0;
    clear_exp();
    load_byte(3, 8'h09, 8'h66);
    exp_mem[8'h09] = 8'h66;
    expect_close("unlock");
    drain(3, 1'b0, "R8 discarded byte absent");
    lock_high = 1'b1;
    seen = 0;
    load_byte(2047, 8'h01, 8'h77);
    repeat (T + 8) begin
      @(negedge clk);
      if (busy || aw_valid) seen++;
    end
    chk(seen == 0, "R8 high region suppressed", seen, 0);
    clear_exp();
    load_byte(1000, 8'h02, 8'h88);
    exp_mem[8'h02] = 8'h88;
    expect_close("midlock");
    drain(1000, 1'b0, "R8 middle page unaffected");
    lock_high = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_window_edge();
    t_backpressure();
    t_lock();
    t_stray();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule